// File: doc/BRIEF.md
# Read-Sequence Nonvolatile Transfer Trigger

This block sits beside the host port of a battery-free nonvolatile memory and turns a hidden pattern of ordinary reads into a command. The host performs six reads at fixed addresses, with nothing else in between. The last address of the six decides the command: a save of the working array into the nonvolatile cells, or a reload of the working array from them. Because only reads are used, a host that knows nothing of the pattern sees a plain memory, and a stray write can never start a transfer.

Access events come from the chip-select and write-strobe lines, which are sampled on the system clock. A read event is a falling chip-select with the write strobe high. A write event is any edge that puts chip-select and the write strobe low together. A transfer controller elsewhere performs the transfer and raises a busy flag while it runs. This block fires a one-cycle request and then stays deaf to the host port until that busy flag has dropped again.

Top module: `nvx_seq_trigger`

## Requirements
- R1: After reset both request outputs are low and the matcher is idle, so a lone read of a final address (0x0F0F or 0x0F0E) raises no request.
- R2: Reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, with no other event between them, raise `store_req` for exactly the clock cycle that follows the clock edge where the sixth read is sampled.
- R3: The same five-read prefix followed by a read at 0x0F0E raises `recall_req` with the same timing.
- R4: Any other sixth address, including the reserved value 0x139C, raises neither request and returns the matcher to idle.
- R5: A write event at any point in the pattern, even to the address the pattern expects next, discards the progress made so far.
- R6: A read at an address other than the next expected one discards the progress made so far. If that read is at 0x0000, it counts as the first step of a new attempt.
- R7: A read event is a high-to-low change of `cs_n`, sampled on a clock edge while `we_n` is high. `oe_n` has no effect. Two chip-select pulses at the same address are two reads, so a repeated step breaks the pattern.
- R8: A completed save pattern raises no request and leaves the block idle and ready when `supply_ok` is low on the edge that samples the sixth read. A completed reload pattern is honoured whatever `supply_ok` is.
- R9: After a request, every host access is ignored until `nv_busy` has been seen high and then low. The clock edge that samples this fall still ignores events, and the next edge accepts them again.
- R10: Each request lasts one cycle, and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (13) | Host address |
| cs_n | input | 1 | Host chip select, active low |
| we_n | input | 1 | Host write strobe, active low |
| oe_n | input | 1 | Host output enable, active low; ignored |
| supply_ok | input | 1 | Supply above the safe threshold for a save |
| nv_busy | input | 1 | Transfer controller is working |
| store_req | output | 1 | One-cycle save request |
| recall_req | output | 1 | One-cycle reload request |

## Verification
The bench builds the block with its default 13-bit address, so every fixed key fits the port exactly. Busy windows of only a few cycles stand in for the long transfer times. This lets a single run cover the lockout, its release, and the first accepted access that follows. It also makes it cheap to restart the pattern right after an abort, after a write and after a suppressed save.

// File: rtl/nvx_seq_pkg.sv
package nvx_seq_pkg;

    localparam int KEY_W      = 13;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef logic [KEY_W-1:0] key_t;

    localparam key_t KEY_SAVE   = 13'h0F0F;
    localparam key_t KEY_RELOAD = 13'h0F0E;

    function automatic key_t prefix_key(input int unsigned idx);
        case (idx)
            0:       return 13'h0000;
            1:       return 13'h1555;
            2:       return 13'h0AAA;
            3:       return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction

    typedef struct packed {
        logic cs;
        logic we;
    } strobe_t;

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } match_t;

    typedef struct packed {
        logic lock;
        logic busy;
        logic save;
        logic reload;
    } gate_t;

endpackage

// File: rtl/nvx_access_detect.sv
module nvx_access_detect
    import nvx_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    output logic rd_evt,
    output logic wr_evt
);

    strobe_t prev_q, prev_d;

    always_comb begin
        prev_d.cs = cs_n;
        prev_d.we = we_n;
        // Falling select with strobe high: a read access begins.
        rd_evt = prev_q.cs & ~cs_n & we_n;
        // Select and strobe both low, entered by either edge.
        wr_evt = ~cs_n & ~we_n & (prev_q.cs | prev_q.we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{cs: 1'b1, we: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/nvx_seq_match.sv
module nvx_seq_match
    import nvx_seq_pkg::*;
#(
    parameter int ADDR_W = KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rd_evt,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_save,
    output logic              hit_reload
);

    localparam int HIT_W = 1 << STEP_W;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

    logic [HIT_W-1:0] key_hit;

    for (genvar g = 0; g < HIT_W; g++) begin : g_key
        if (g < PREFIX_LEN) begin : g_cmp
            assign key_hit[g] = (addr == ADDR_W'(prefix_key(g)));
        end else begin : g_pad
            assign key_hit[g] = 1'b0;
        end
    end

    match_t q, d;

    always_comb begin
        d          = q;
        hit_save   = 1'b0;
        hit_reload = 1'b0;
        if (!enable || wr_evt) begin
            d.step = '0;
        end else if (rd_evt) begin
            if (q.step == LAST_STEP) begin
                hit_save   = (addr == ADDR_W'(KEY_SAVE));
                hit_reload = (addr == ADDR_W'(KEY_RELOAD));
                d.step     = key_hit[0] ? STEP_W'(1) : '0;
            end else if (key_hit[q.step]) begin
                d.step = q.step + STEP_W'(1);
            end else begin
                // Abort; an entry read restarts immediately.
                d.step = key_hit[0] ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nvx_req_gate.sv
module nvx_req_gate
    import nvx_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_save,
    input  logic hit_reload,
    input  logic supply_ok,
    input  logic nv_busy,
    output logic locked,
    output logic store_req,
    output logic recall_req
);

    gate_t q, d;

    always_comb begin
        d        = q;
        d.busy   = nv_busy;
        d.save   = 1'b0;
        d.reload = 1'b0;
        if (q.lock) begin
            if (q.busy && !nv_busy) begin
                d.lock = 1'b0;
            end
        end else if (hit_reload) begin
            d.reload = 1'b1;
            d.lock   = 1'b1;
        end else if (hit_save && supply_ok) begin
            d.save = 1'b1;
            d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign locked     = q.lock;
    assign store_req  = q.save;
    assign recall_req = q.reload;

endmodule

// File: rtl/nvx_seq_trigger.sv
module nvx_seq_trigger
    import nvx_seq_pkg::*;
#(
    parameter int ADDR_W = KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_ok,
    input  logic              nv_busy,
    output logic              store_req,
    output logic              recall_req
);

    logic rd_evt;
    logic wr_evt;
    logic hit_save;
    logic hit_reload;
    logic locked;
    logic oe_unused;

    // Output enable plays no part in recognising the pattern.
    assign oe_unused = oe_n;

    nvx_access_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .we_n   (we_n),
        .rd_evt (rd_evt),
        .wr_evt (wr_evt)
    );

    nvx_seq_match #(
        .ADDR_W (ADDR_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (~locked),
        .rd_evt     (rd_evt),
        .wr_evt     (wr_evt),
        .addr       (addr),
        .hit_save   (hit_save),
        .hit_reload (hit_reload)
    );

    nvx_req_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_save   (hit_save),
        .hit_reload (hit_reload),
        .supply_ok  (supply_ok),
        .nv_busy    (nv_busy),
        .locked     (locked),
        .store_req  (store_req),
        .recall_req (recall_req)
    );

endmodule

// File: rtl/nvx_seq_trigger_chk.sv
module nvx_seq_trigger_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic we_n,
    input logic supply_ok,
    input logic nv_busy,
    input logic store_req,
    input logic recall_req
);

    logic pend_q;
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= nv_busy;
            if (busy_q && !nv_busy)              pend_q <= 1'b0;
            else if (store_req || recall_req)    pend_q <= 1'b1;
        end
    end

    AST_SAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req); // R10
    AST_RELOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req); // R10
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req)); // R10
    AST_SAVE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(supply_ok)); // R8
    AST_REQ_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> $past(!cs_n && we_n)); // R7
    AST_NO_REQ_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !(store_req || recall_req)); // R9

endmodule

bind nvx_seq_trigger nvx_seq_trigger_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .supply_ok  (supply_ok),
    .nv_busy    (nv_busy),
    .store_req  (store_req),
    .recall_req (recall_req)
);

// File: tb/nvx_seq_trigger_tb.sv
module nvx_seq_trigger_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        cs_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        supply_ok = 1'b1;
    logic        nv_busy = 1'b0;
    logic        store_req;
    logic        recall_req;

    int checks = 0;
    int errors = 0;
    int st_cnt = 0;
    int rc_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nvx_seq_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .supply_ok(supply_ok), .nv_busy(nv_busy),
        .store_req(store_req), .recall_req(recall_req)
    );

    // Behavioural reference model
    int keys[$] = '{'h0000, 'h1555, 'h0AAA, 'h1FFF, 'h10F0};
    int pos = 0;
    bit m_lock = 0, p_cs = 1, p_we = 1, p_busy = 0;
    bit exp_st = 0, exp_rc = 0;
    bit prev_st = 0, prev_rc = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos = 0; m_lock = 0; p_cs = 1; p_we = 1; p_busy = 0;
            exp_st = 0; exp_rc = 0;
        end else begin
            bit rd, wr;
            rd = p_cs && !cs_n && we_n;
            wr = !cs_n && !we_n && (p_cs || p_we);
            exp_st = 0; exp_rc = 0;
            if (m_lock) begin
                pos = 0;
                if (p_busy && !nv_busy) m_lock = 0;
            end else if (wr) begin
                pos = 0;
            end else if (rd) begin
                if (pos == keys.size()) begin
                    if (addr == 13'h0F0E) begin exp_rc = 1; m_lock = 1; end
                    else if (addr == 13'h0F0F && supply_ok) begin exp_st = 1; m_lock = 1; end
                    pos = (addr == 0) ? 1 : 0;
                end else if (int'(addr) == keys[pos]) begin
                    pos++;
                end else begin
                    pos = (addr == 0) ? 1 : 0;
                end
            end
            p_cs = cs_n; p_we = we_n; p_busy = nv_busy;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(store_req == exp_st, "R2 store model", store_req, exp_st);
            check(recall_req == exp_rc, "R3 recall model", recall_req, exp_rc);
            if (store_req && prev_st) check(0, "R10 store width", 2, 1);
            if (recall_req && prev_rc) check(0, "R10 recall width", 2, 1);
            if (store_req && recall_req) check(0, "R10 exclusive", 2, 1);
            st_cnt += store_req;
            rc_cnt += recall_req;
            prev_st = store_req;
            prev_rc = recall_req;
        end
    end

    task automatic rd(input logic [12:0] a, input logic oe = 1'b0);
        @(negedge clk); addr = a; oe_n = oe; we_n = 1'b1; cs_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [12:0] a);
        @(negedge clk); addr = a; we_n = 1'b0; cs_n = 1'b0;
        @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic prefix(input logic oe = 1'b0);
        rd(13'h0000, oe); rd(13'h1555, ~oe); rd(13'h0AAA, oe);
        rd(13'h1FFF, ~oe); rd(13'h10F0, oe);
    endtask

    task automatic serve(input int n);
        repeat (2) @(negedge clk);
        nv_busy = 1'b1;
        repeat (n) @(negedge clk);
        nv_busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_counts(input int s, input int r, input string tag);
        check(st_cnt == s, tag, st_cnt, s);
        check(rc_cnt == r, tag, rc_cnt, r);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, lone final reads do nothing
        check(store_req == 0 && recall_req == 0, "R1 reset outputs", store_req, 0);
        rd(13'h0F0F); rd(13'h0F0E);
        expect_counts(0, 0, "R1 idle");

        // R2: save pattern
        prefix(); rd(13'h0F0F);
        expect_counts(1, 0, "R2 save");
        serve(4);

        // R3 with R7: reload pattern with output enable toggling
        prefix(1'b1); rd(13'h0F0E, 1'b1);
        expect_counts(1, 1, "R3 reload");
        serve(3);

        // R4: reserved and arbitrary last addresses
        prefix(); rd(13'h139C);
        prefix(); rd(13'h1234);
        expect_counts(1, 1, "R4 no trigger");

        // R5: write in the middle, even to the expected address
        rd(13'h0000); rd(13'h1555); wr(13'h0AAA); rd(13'h0AAA);
        rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        expect_counts(1, 1, "R5 write abort");

        // R6: wrong read aborts; a 0x0000 read restarts
        rd(13'h0000); rd(13'h1555); rd(13'h0000); rd(13'h1555);
        rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        expect_counts(2, 1, "R6 restart save");
        serve(2);
        rd(13'h0000); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0E);
        expect_counts(2, 1, "R6 skip abort");

        // R7: repeated chip-select pulse at the same address breaks it
        rd(13'h0000); rd(13'h1555); rd(13'h1555); rd(13'h0AAA);
        rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0E);
        expect_counts(2, 1, "R7 repeat pulse");

        // R8: low supply blocks save, not reload, and leaves no lock
        supply_ok = 1'b0;
        prefix(); rd(13'h0F0F);
        expect_counts(2, 1, "R8 save suppressed");
        prefix(); rd(13'h0F0E);
        expect_counts(2, 2, "R8 reload allowed");
        serve(3);
        supply_ok = 1'b1;

        // R9: accesses ignored until busy falls
        prefix(); rd(13'h0F0F);
        expect_counts(3, 2, "R9 save issued");
        prefix(); rd(13'h0F0E);
        expect_counts(3, 2, "R9 locked before busy");
        nv_busy = 1'b1;
        prefix(); rd(13'h0F0E);
        expect_counts(3, 2, "R9 locked while busy");
        nv_busy = 1'b0;
        @(negedge clk);
        prefix(); rd(13'h0F0E);
        expect_counts(3, 3, "R9 released");
        serve(2);

        // R10: back-to-back patterns each yield single pulses
        prefix(); rd(13'h0F0F);
        serve(1);
        prefix(); rd(13'h0F0F);
        serve(1);
        expect_counts(5, 3, "R10 pulses");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule